// File: doc/BRIEF.md
# Single-Cycle Integer Core

This block is a small processor that completes one instruction per clock. Each cycle it reads a 32-bit instruction word at the program counter, decodes one of three fixed layouts, reads two operands from a 32-entry register file, computes a result, and in the same clock edge writes the register file or data memory and moves the program counter. Arithmetic works only on registers. Memory is reached only through the load-word and store-word operations. The supported set is add, subtract, signed set-less-than, their immediate forms, bitwise AND and OR with a zero-extended constant, load-upper, word load and store, the two equality branches, and an absolute jump.

Instruction memory and data memory are internal word arrays. The environment fills them through a write port that is honoured only while reset is held low, and the core does not execute while reset is low. After reset is released the core runs the loaded program from address 0. A read-only observation port shows any register and any memory word, so the final machine state can be checked.

Top module: `rcore_top`

## Requirements
- R1: While rst_n is low at a rising edge, the program counter becomes 0 and every register reads 0 from the next edge on.
- R2: An R-layout word (op 0x00) has fields op[31:26], rs[25:21], rt[20:16], rd[15:11], shamt[10:6] and funct[5:0]. funct 0x20 writes rd with rs+rt, 0x22 writes rs−rt, and 0x2A writes 1 if rs is less than rt as signed numbers, else 0.
- R3: An I-layout word holds op, rs, rt and a 16-bit constant in [15:0], with the result going to rt. op 0x08 adds the sign-extended constant, 0x0A is a signed set-less-than against the sign-extended constant, 0x0C and 0x0D AND and OR with the zero-extended constant, and 0x0F places the constant in bits [31:16] with zeros below.
- R4: Register 0 always reads as zero and writes to it are discarded, so an add with register 0 copies a register.
- R5: Addresses are byte addresses equal to rs plus the sign-extended constant, and bits [1:0] are ignored. op 0x23 loads that data word into rt. op 0x2B stores rt to that word at the clock edge, and a load in the next cycle returns the new value.
- R6: Every instruction that is not a taken branch or a jump advances the program counter by 4.
- R7: op 0x04 (equal) and op 0x05 (not equal) compare rs with rt. When taken, the next PC is PC+4 plus the sign-extended constant shifted left by 2. Otherwise the next PC is PC+4.
- R8: op 0x02 (J-layout, 26-bit field in [25:0]) sets the PC to bits [31:28] of PC+4, then the field, then two zero bits.
- R9: An unlisted op, or an R-layout word with an unlisted funct, writes neither registers nor memory and advances the PC by 4.
- R10: While rst_n is low, a high load_en writes load_data at word index load_addr into instruction memory (load_sel 0) or data memory (load_sel 1), and the program then starts at address 0 once reset is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset; also enables preloading |
| load_en | input | 1 | Preload write strobe, honoured only in reset |
| load_sel | input | 1 | Preload target: 0 instruction memory, 1 data memory |
| load_addr | input | LD_AW | Preload word index |
| load_data | input | 32 | Preload word |
| pc_o | output | 32 | Current program counter |
| peek_reg_sel | input | 5 | Register index to observe |
| peek_reg_data | output | 32 | Contents of the selected register |
| peek_mem_sel | input | 1 | Memory to observe: 0 instruction, 1 data |
| peek_mem_addr | input | LD_AW | Word index to observe |
| peek_mem_data | output | 32 | Contents of the selected memory word |

## Verification
Because every instruction finishes in one cycle, a wrong decoded control bit or register value is committed at the very edge that executes it. It shows on the observation port one cycle later as a wrong destination register, a wrong data word or a skipped store. A wrong next-PC computation shows on pc_o one cycle later, and afterwards as missing or extra register updates from the instructions that were skipped or executed by mistake. The directed programs therefore make every instruction leave a distinct value behind, and they include instructions that must be skipped. The final state then shows which path the program took.

// File: rtl/rcore_pkg.sv
// Shared encodings and control bundle for the single-cycle core.
// Assumes a 32-bit word and three fixed instruction layouts.
package rcore_pkg;

    localparam int XLEN = 32;
    localparam int RAW  = 5;

    localparam logic [5:0] OPC_RTYPE = 6'h00;
    localparam logic [5:0] OPC_JUMP  = 6'h02;
    localparam logic [5:0] OPC_BEQ   = 6'h04;
    localparam logic [5:0] OPC_BNE   = 6'h05;
    localparam logic [5:0] OPC_ADDI  = 6'h08;
    localparam logic [5:0] OPC_SLTI  = 6'h0A;
    localparam logic [5:0] OPC_ANDI  = 6'h0C;
    localparam logic [5:0] OPC_ORI   = 6'h0D;
    localparam logic [5:0] OPC_LUI   = 6'h0F;
    localparam logic [5:0] OPC_LW    = 6'h23;
    localparam logic [5:0] OPC_SW    = 6'h2B;

    localparam logic [5:0] FN_ADD = 6'h20;
    localparam logic [5:0] FN_SUB = 6'h22;
    localparam logic [5:0] FN_SLT = 6'h2A;

    typedef enum logic [2:0] {
        ALU_ADD,
        ALU_SUB,
        ALU_SLT,
        ALU_AND,
        ALU_OR,
        ALU_PASSB
    } alu_op_e;

    typedef enum logic [1:0] {
        IMM_SIGN,
        IMM_ZERO,
        IMM_UPPER
    } imm_kind_e;

    typedef struct packed {
        logic      reg_we;
        logic      dst_rd;
        logic      use_imm;
        imm_kind_e imm_kind;
        alu_op_e   alu_op;
        logic      mem_rd;
        logic      mem_wr;
        logic      br_eq;
        logic      br_ne;
        logic      jump;
    } ctrl_t;

endpackage

// File: rtl/rcore_decode.sv
// Instruction decoder: turns op and funct into the control bundle.
// Assumes unknown codes decode to a bundle with every write disabled.
module rcore_decode
    import rcore_pkg::*;
(
    input  logic [5:0] op,
    input  logic [5:0] funct,
    output ctrl_t      ctrl
);

    // Decode the operation into control bits; unlisted codes stay inert.
    always_comb begin
        ctrl          = '0;
        ctrl.imm_kind = IMM_SIGN;
        ctrl.alu_op   = ALU_ADD;
        case (op)
            OPC_RTYPE: begin
                ctrl.dst_rd = 1'b1;
                case (funct)
                    FN_ADD: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_ADD; end
                    FN_SUB: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SUB; end
                    FN_SLT: begin ctrl.reg_we = 1'b1; ctrl.alu_op = ALU_SLT; end
                    default: ctrl.reg_we = 1'b0;
                endcase
            end
            OPC_ADDI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_ADD;
            end
            OPC_SLTI: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.alu_op  = ALU_SLT;
            end
            OPC_ANDI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_ZERO;
                ctrl.alu_op   = ALU_AND;
            end
            OPC_ORI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_ZERO;
                ctrl.alu_op   = ALU_OR;
            end
            OPC_LUI: begin
                ctrl.reg_we   = 1'b1;
                ctrl.use_imm  = 1'b1;
                ctrl.imm_kind = IMM_UPPER;
                ctrl.alu_op   = ALU_PASSB;
            end
            OPC_LW: begin
                ctrl.reg_we  = 1'b1;
                ctrl.use_imm = 1'b1;
                ctrl.mem_rd  = 1'b1;
            end
            OPC_SW: begin
                ctrl.use_imm = 1'b1;
                ctrl.mem_wr  = 1'b1;
            end
            OPC_BEQ:  ctrl.br_eq = 1'b1;
            OPC_BNE:  ctrl.br_ne = 1'b1;
            OPC_JUMP: ctrl.jump  = 1'b1;
            default:  ctrl.reg_we = 1'b0;
        endcase
    end

endmodule

// File: rtl/rcore_alu.sv
// Integer ALU: add, subtract, signed less-than, AND, OR and pass-through.
// Assumes two's-complement operands; overflow is not flagged.
module rcore_alu
    import rcore_pkg::*;
#(
    parameter int W = XLEN
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  alu_op_e      op,
    output logic [W-1:0] y
);

    // Select the result of the requested operation.
    always_comb begin
        case (op)
            ALU_ADD:   y = a + b;
            ALU_SUB:   y = a - b;
            ALU_SLT:   y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
            ALU_AND:   y = a & b;
            ALU_OR:    y = a | b;
            ALU_PASSB: y = b;
            default:   y = '0;
        endcase
    end

endmodule

// File: rtl/rcore_regfile.sv
// General register file with NRD combinational read ports and one write port.
// Assumes index 0 is hardwired to zero; writes to it are dropped.
module rcore_regfile #(
    parameter int W   = 32,
    parameter int AW  = 5,
    parameter int NRD = 3
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    we,
    input  logic [AW-1:0]           waddr,
    input  logic [W-1:0]            wdata,
    input  logic [NRD-1:0][AW-1:0]  raddr,
    output logic [NRD-1:0][W-1:0]   rdata
);

    localparam int NREG = 1 << AW;

    logic [W-1:0] regs [NREG];

    // Clear on reset, otherwise commit one write to a nonzero index.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) begin
                regs[i] <= '0;
            end
        end else if (we && (waddr != '0)) begin
            regs[waddr] <= wdata;
        end
    end

    for (genvar g = 0; g < NRD; g++) begin : g_rd
        assign rdata[g] = (raddr[g] == '0) ? '0 : regs[raddr[g]];
    end

endmodule

// File: rtl/rcore_wordmem.sv
// Word-wide memory: one synchronous write port, two combinational read ports.
// Assumes contents are undefined until written; no reset of storage.
module rcore_wordmem #(
    parameter int W  = 32,
    parameter int AW = 6
) (
    input  logic          clk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [W-1:0]  wdata,
    input  logic [AW-1:0] raddr_a,
    output logic [W-1:0]  rdata_a,
    input  logic [AW-1:0] raddr_b,
    output logic [W-1:0]  rdata_b
);

    localparam int DEPTH = 1 << AW;

    logic [W-1:0] mem [DEPTH];

    // Store one word at the clock edge when enabled.
    always_ff @(posedge clk) begin
        if (we) begin
            mem[waddr] <= wdata;
        end
    end

    assign rdata_a = mem[raddr_a];
    assign rdata_b = mem[raddr_b];

endmodule

// File: rtl/rcore_top.sv
// Single-cycle core: fetch, decode, execute, memory and write-back in one clock.
// Assumes memories are filled through the load port while rst_n is low and that
// addresses wrap modulo each memory's depth.
module rcore_top
    import rcore_pkg::*;
#(
    parameter int IMEM_AW = 6,
    parameter int DMEM_AW = 6,
    localparam int LD_AW  = (IMEM_AW > DMEM_AW) ? IMEM_AW : DMEM_AW
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_en,
    input  logic             load_sel,
    input  logic [LD_AW-1:0] load_addr,
    input  logic [31:0]      load_data,
    output logic [31:0]      pc_o,
    input  logic [4:0]       peek_reg_sel,
    output logic [31:0]      peek_reg_data,
    input  logic             peek_mem_sel,
    input  logic [LD_AW-1:0] peek_mem_addr,
    output logic [31:0]      peek_mem_data
);

    logic [31:0] pc_q;
    logic [31:0] pc_plus4;
    logic [31:0] pc_next;
    logic [31:0] instr;
    logic [5:0]  op;
    logic [5:0]  funct;
    logic [4:0]  rs_idx;
    logic [4:0]  rt_idx;
    logic [4:0]  rd_idx;
    logic [15:0] imm16;
    logic [25:0] jfield;
    ctrl_t       ctrl;
    logic [31:0] imm_sext;
    logic [31:0] imm_ext;
    logic [31:0] rs_val;
    logic [31:0] rt_val;
    logic [31:0] alu_b;
    logic [31:0] alu_y;
    logic [31:0] wb_data;
    logic [4:0]  wb_idx;
    logic        br_take;
    logic        dmem_we_core;
    logic        imem_we;
    logic        dmem_we;
    logic [DMEM_AW-1:0] dmem_waddr;
    logic [31:0] dmem_wdata;
    logic [31:0] dmem_rdata;
    logic [31:0] imem_peek;
    logic [31:0] dmem_peek;
    logic [2:0][4:0]  rf_raddr;
    logic [2:0][31:0] rf_rdata;

    // Instruction fields at fixed positions.
    assign op     = instr[31:26];
    assign rs_idx = instr[25:21];
    assign rt_idx = instr[20:16];
    assign rd_idx = instr[15:11];
    assign funct  = instr[5:0];
    assign imm16  = instr[15:0];
    assign jfield = instr[25:0];

    // Program counter: cleared by reset, otherwise loads the chosen successor.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pc_q <= '0;
        end else begin
            pc_q <= pc_next;
        end
    end

    assign pc_o     = pc_q;
    assign pc_plus4 = pc_q + 32'd4;

    // Instruction memory: preload port in reset, fetch by word index of the PC.
    assign imem_we = !rst_n && load_en && !load_sel;

    rcore_wordmem #(.W(32), .AW(IMEM_AW)) u_imem (
        .clk     (clk),
        .we      (imem_we),
        .waddr   (load_addr[IMEM_AW-1:0]),
        .wdata   (load_data),
        .raddr_a (pc_q[IMEM_AW+1:2]),
        .rdata_a (instr),
        .raddr_b (peek_mem_addr[IMEM_AW-1:0]),
        .rdata_b (imem_peek)
    );

    rcore_decode u_dec (
        .op    (op),
        .funct (funct),
        .ctrl  (ctrl)
    );

    // Register file: port 0 rs, port 1 rt, port 2 observation.
    assign rf_raddr[0] = rs_idx;
    assign rf_raddr[1] = rt_idx;
    assign rf_raddr[2] = peek_reg_sel;
    assign rs_val        = rf_rdata[0];
    assign rt_val        = rf_rdata[1];
    assign peek_reg_data = rf_rdata[2];

    rcore_regfile #(.W(32), .AW(RAW), .NRD(3)) u_rf (
        .clk   (clk),
        .rst_n (rst_n),
        .we    (ctrl.reg_we && rst_n),
        .waddr (wb_idx),
        .wdata (wb_data),
        .raddr (rf_raddr),
        .rdata (rf_rdata)
    );

    // Form the constant operand according to the decoded extension kind.
    assign imm_sext = {{16{imm16[15]}}, imm16};

    always_comb begin
        case (ctrl.imm_kind)
            IMM_ZERO:  imm_ext = {16'h0000, imm16};
            IMM_UPPER: imm_ext = {imm16, 16'h0000};
            default:   imm_ext = imm_sext;
        endcase
    end

    assign alu_b = ctrl.use_imm ? imm_ext : rt_val;

    rcore_alu #(.W(32)) u_alu (
        .a  (rs_val),
        .b  (alu_b),
        .op (ctrl.alu_op),
        .y  (alu_y)
    );

    // Data memory: preload in reset, store from the core when running.
    assign dmem_we_core = rst_n && ctrl.mem_wr;
    assign dmem_we      = dmem_we_core || (!rst_n && load_en && load_sel);
    assign dmem_waddr   = rst_n ? alu_y[DMEM_AW+1:2] : load_addr[DMEM_AW-1:0];
    assign dmem_wdata   = rst_n ? rt_val : load_data;

    rcore_wordmem #(.W(32), .AW(DMEM_AW)) u_dmem (
        .clk     (clk),
        .we      (dmem_we),
        .waddr   (dmem_waddr),
        .wdata   (dmem_wdata),
        .raddr_a (alu_y[DMEM_AW+1:2]),
        .rdata_a (dmem_rdata),
        .raddr_b (peek_mem_addr[DMEM_AW-1:0]),
        .rdata_b (dmem_peek)
    );

    assign peek_mem_data = peek_mem_sel ? dmem_peek : imem_peek;

    // Write-back selection.
    assign wb_data = ctrl.mem_rd ? dmem_rdata : alu_y;
    assign wb_idx  = ctrl.dst_rd ? rd_idx : rt_idx;

    // Next-PC selection among sequential, branch and jump targets.
    assign br_take = (ctrl.br_eq && (rs_val == rt_val)) ||
                     (ctrl.br_ne && (rs_val != rt_val));

    always_comb begin
        if (ctrl.jump) begin
            pc_next = {pc_plus4[31:28], jfield, 2'b00};
        end else if (br_take) begin
            pc_next = pc_plus4 + {imm_sext[29:0], 2'b00};
        end else begin
            pc_next = pc_plus4;
        end
    end

    logic unused_bits;
    assign unused_bits = ^{instr[10:6], pc_q[1:0], alu_y[1:0], alu_y[31:DMEM_AW+2],
                           pc_q[31:IMEM_AW+2], load_addr, peek_mem_addr};

endmodule

// File: rtl/rcore_top_chk.sv
// Property checker for rcore_top, attached by bind below.
// Assumes the core's internal PC, instruction and operand nets by name.
module rcore_top_chk (
    input logic        clk,
    input logic        rst_n,
    input logic [31:0] pc_q,
    input logic [31:0] instr,
    input logic [31:0] rs_val,
    input logic [31:0] rt_val,
    input logic        dmem_we_core
);

    logic [5:0]  c_op;
    logic [31:0] c_br_tgt;
    logic [31:0] c_j_tgt;
    logic [31:0] c_pc4;

    assign c_op     = instr[31:26];
    assign c_pc4    = pc_q + 32'd4;
    assign c_br_tgt = c_pc4 + {{14{instr[15]}}, instr[15:0], 2'b00};
    assign c_j_tgt  = {c_pc4[31:28], instr[25:0], 2'b00};

    // R1: reset forces the PC to zero
    a_r1_pc_reset: assert property (@(posedge clk)
        !rst_n |=> (pc_q == 32'd0));

    // R6: non-control instructions step the PC by one word
    a_r6_pc_step: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_op != 6'h02) && (c_op != 6'h04) && (c_op != 6'h05)) |=> (pc_q == $past(c_pc4)));

    // R7: a taken equal-branch reaches its relative target
    a_r7_beq_taken: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_op == 6'h04) && (rs_val == rt_val)) |=> (pc_q == $past(c_br_tgt)));

    // R7: an untaken not-equal branch falls through
    a_r7_bne_fall: assert property (@(posedge clk) disable iff (!rst_n)
        ((c_op == 6'h05) && (rs_val == rt_val)) |=> (pc_q == $past(c_pc4)));

    // R8: jump target assembled from PC+4 upper bits and the field
    a_r8_jump: assert property (@(posedge clk) disable iff (!rst_n)
        (c_op == 6'h02) |=> (pc_q == $past(c_j_tgt)));

    // R4: register 0 reads as zero
    a_r4_zero_read: assert property (@(posedge clk) disable iff (!rst_n)
        (instr[25:21] == 5'd0) |-> (rs_val == 32'd0));

    // R5: R9: the core writes data memory only for a store word
    a_r5_store_only: assert property (@(posedge clk) disable iff (!rst_n)
        dmem_we_core |-> (c_op == 6'h2B));

endmodule

bind rcore_top rcore_top_chk chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .pc_q         (pc_q),
    .instr        (instr),
    .rs_val       (rs_val),
    .rt_val       (rt_val),
    .dmem_we_core (dmem_we_core)
);

// File: tb/rcore_top_tb_top.sv
// Directed bench: one task per scenario, each loads a program in reset,
// runs it, and checks registers, memory and PC through the observation port.
module rcore_top_tb_top;

    localparam int LD_AW = 6;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             load_en = 1'b0;
    logic             load_sel = 1'b0;
    logic [LD_AW-1:0] load_addr = '0;
    logic [31:0]      load_data = '0;
    logic [31:0]      pc_o;
    logic [4:0]       peek_reg_sel = '0;
    logic [31:0]      peek_reg_data;
    logic             peek_mem_sel = 1'b0;
    logic [LD_AW-1:0] peek_mem_addr = '0;
    logic [31:0]      peek_mem_data;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #2 clk = ~clk;

    rcore_top dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .load_en       (load_en),
        .load_sel      (load_sel),
        .load_addr     (load_addr),
        .load_data     (load_data),
        .pc_o          (pc_o),
        .peek_reg_sel  (peek_reg_sel),
        .peek_reg_data (peek_reg_data),
        .peek_mem_sel  (peek_mem_sel),
        .peek_mem_addr (peek_mem_addr),
        .peek_mem_data (peek_mem_data)
    );

    function automatic logic [31:0] enc_r(input logic [4:0] rs, input logic [4:0] rt,
                                          input logic [4:0] rd, input logic [5:0] fn);
        return {6'h00, rs, rt, rd, 5'd0, fn};
    endfunction

    function automatic logic [31:0] enc_i(input logic [5:0] op, input logic [4:0] rs,
                                          input logic [4:0] rt, input logic [15:0] k);
        return {op, rs, rt, k};
    endfunction

    function automatic logic [31:0] enc_j(input logic [25:0] a);
        return {6'h02, a};
    endfunction

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic enter_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
    endtask

    task automatic put(input logic sel, input int idx, input logic [31:0] val);
        load_en   = 1'b1;
        load_sel  = sel;
        load_addr = LD_AW'(idx);
        load_data = val;
        @(negedge clk);
        load_en   = 1'b0;
    endtask

    task automatic run(input int cycles);
        rst_n = 1'b1;
        repeat (cycles) @(posedge clk);
        @(negedge clk);
    endtask

    task automatic chk_reg(input string tag, input int idx, input logic [31:0] exp);
        peek_reg_sel = 5'(idx);
        #1;
        check(tag, peek_reg_data, exp);
    endtask

    task automatic chk_mem(input string tag, input int idx, input logic [31:0] exp);
        peek_mem_sel  = 1'b1;
        peek_mem_addr = LD_AW'(idx);
        #1;
        check(tag, peek_mem_data, exp);
    endtask

    // R1 R10: reset state and preload while held in reset
    task automatic t_reset_preload();
        enter_reset();
        put(1'b0, 0, enc_i(6'h08, 5'd0, 5'd1, 16'd1));
        put(1'b0, 1, enc_j(26'd1));
        repeat (6) @(negedge clk);
        #1;
        check("R1 pc in reset", pc_o, 32'd0);
        chk_reg("R1 reg1 in reset", 1, 32'd0);
        chk_reg("R1 reg31 in reset", 31, 32'd0);
        peek_mem_sel = 1'b0; peek_mem_addr = '0; #1;
        check("R10 imem word0 preloaded", peek_mem_data, enc_i(6'h08, 5'd0, 5'd1, 16'd1));
        run(5);
        chk_reg("R10 program ran from 0", 1, 32'd1);
        check("R10 pc parked", pc_o, 32'd4);
    endtask

    // R2 R3 R6: register and immediate arithmetic
    task automatic t_arith();
        enter_reset();
        put(1'b0, 0,  enc_i(6'h08, 5'd0, 5'd1, 16'd7));
        put(1'b0, 1,  enc_i(6'h08, 5'd0, 5'd2, 16'hFFFD));
        put(1'b0, 2,  enc_r(5'd1, 5'd2, 5'd3, 6'h20));
        put(1'b0, 3,  enc_r(5'd2, 5'd1, 5'd4, 6'h22));
        put(1'b0, 4,  enc_r(5'd2, 5'd1, 5'd5, 6'h2A));
        put(1'b0, 5,  enc_r(5'd1, 5'd2, 5'd6, 6'h2A));
        put(1'b0, 6,  enc_i(6'h0A, 5'd2, 5'd7, 16'hFFFE));
        put(1'b0, 7,  enc_i(6'h0C, 5'd2, 5'd8, 16'hF0F0));
        put(1'b0, 8,  enc_i(6'h0D, 5'd0, 5'd9, 16'h8001));
        put(1'b0, 9,  enc_i(6'h0F, 5'd0, 5'd10, 16'h1234));
        put(1'b0, 10, enc_i(6'h0D, 5'd10, 5'd10, 16'h5678));
        put(1'b0, 11, enc_j(26'd11));
        rst_n = 1'b1;
        @(posedge clk); @(negedge clk);
        check("R6 pc after first step", pc_o, 32'd4);
        run(20);
        chk_reg("R3 addi positive", 1, 32'd7);
        chk_reg("R3 addi sign-extended", 2, 32'hFFFF_FFFD);
        chk_reg("R2 add", 3, 32'd4);
        chk_reg("R2 sub negative", 4, 32'hFFFF_FFF6);
        chk_reg("R2 slt signed true", 5, 32'd1);
        chk_reg("R2 slt signed false", 6, 32'd0);
        chk_reg("R3 slti signed", 7, 32'd1);
        chk_reg("R3 andi zero-extended", 8, 32'h0000_F0F0);
        chk_reg("R3 ori zero-extended", 9, 32'h0000_8001);
        chk_reg("R3 lui then ori", 10, 32'h1234_5678);
        check("R6 pc at halt", pc_o, 32'd44);
    endtask

    // R4: register zero
    task automatic t_zero_reg();
        enter_reset();
        put(1'b0, 0, enc_i(6'h08, 5'd0, 5'd0, 16'd55));
        put(1'b0, 1, enc_i(6'h08, 5'd0, 5'd1, 16'd9));
        put(1'b0, 2, enc_r(5'd0, 5'd1, 5'd2, 6'h20));
        put(1'b0, 3, enc_j(26'd3));
        run(10);
        chk_reg("R4 reg0 write dropped", 0, 32'd0);
        chk_reg("R4 source read", 1, 32'd9);
        chk_reg("R4 move via add with reg0", 2, 32'd9);
        check("R4 pc at halt", pc_o, 32'd12);
    endtask

    // R5: word loads and stores
    task automatic t_memory();
        enter_reset();
        put(1'b1, 2, 32'hCAFE_F00D);
        put(1'b1, 5, 32'h1111_2222);
        put(1'b1, 0, 32'h0);
        put(1'b1, 3, 32'h0);
        put(1'b0, 0, enc_i(6'h08, 5'd0, 5'd1, 16'd4));
        put(1'b0, 1, enc_i(6'h23, 5'd1, 5'd2, 16'd4));
        put(1'b0, 2, enc_i(6'h23, 5'd0, 5'd3, 16'd20));
        put(1'b0, 3, enc_r(5'd2, 5'd3, 5'd4, 6'h20));
        put(1'b0, 4, enc_i(6'h2B, 5'd1, 5'd4, 16'hFFFC));
        put(1'b0, 5, enc_i(6'h2B, 5'd1, 5'd3, 16'd8));
        put(1'b0, 6, enc_i(6'h23, 5'd0, 5'd6, 16'd0));
        put(1'b0, 7, enc_j(26'd7));
        run(15);
        chk_reg("R5 load base+offset", 2, 32'hCAFE_F00D);
        chk_reg("R5 load absolute", 3, 32'h1111_2222);
        chk_reg("R5 load after store", 6, 32'hDC10_122F);
        chk_mem("R5 store negative offset", 0, 32'hDC10_122F);
        chk_mem("R5 store positive offset", 3, 32'h1111_2222);
        chk_mem("R5 untouched word", 2, 32'hCAFE_F00D);
    endtask

    // R7 R8: branches and jump
    task automatic t_branch();
        enter_reset();
        put(1'b0, 0,  enc_i(6'h08, 5'd0, 5'd1, 16'd5));
        put(1'b0, 1,  enc_i(6'h08, 5'd0, 5'd2, 16'd5));
        put(1'b0, 2,  enc_i(6'h04, 5'd1, 5'd2, 16'd2));
        put(1'b0, 3,  enc_i(6'h08, 5'd0, 5'd3, 16'd1));
        put(1'b0, 4,  enc_i(6'h08, 5'd0, 5'd3, 16'd2));
        put(1'b0, 5,  enc_i(6'h05, 5'd1, 5'd2, 16'd5));
        put(1'b0, 6,  enc_i(6'h08, 5'd0, 5'd4, 16'd3));
        put(1'b0, 7,  enc_i(6'h08, 5'd2, 5'd2, 16'd1));
        put(1'b0, 8,  enc_i(6'h05, 5'd1, 5'd2, 16'd1));
        put(1'b0, 9,  enc_i(6'h08, 5'd0, 5'd5, 16'd9));
        put(1'b0, 10, enc_j(26'd12));
        put(1'b0, 11, enc_i(6'h08, 5'd0, 5'd6, 16'd1));
        put(1'b0, 12, enc_i(6'h04, 5'd0, 5'd0, 16'hFFFF));
        run(20);
        chk_reg("R7 beq taken skips", 3, 32'd0);
        chk_reg("R7 bne untaken falls through", 4, 32'd3);
        chk_reg("R7 counter updated", 2, 32'd6);
        chk_reg("R7 bne taken skips", 5, 32'd0);
        chk_reg("R8 jump skips", 6, 32'd0);
        check("R7 backward branch holds pc", pc_o, 32'd48);
    endtask

    // R9: unrecognised encodings are inert
    task automatic t_illegal();
        enter_reset();
        put(1'b1, 0, 32'hA5A5_A5A5);
        put(1'b0, 0, enc_i(6'h08, 5'd0, 5'd1, 16'd1));
        put(1'b0, 1, 32'hFC21_FFFF);
        put(1'b0, 2, enc_r(5'd1, 5'd1, 5'd1, 6'h3F));
        put(1'b0, 3, enc_i(6'h08, 5'd0, 5'd2, 16'd4));
        put(1'b0, 4, enc_j(26'd4));
        run(10);
        chk_reg("R9 unknown op no write", 1, 32'd1);
        chk_reg("R9 execution continues", 2, 32'd4);
        chk_mem("R9 memory untouched", 0, 32'hA5A5_A5A5);
        check("R9 pc advanced", pc_o, 32'd16);
    endtask

    task automatic finish_run();
        $display("  End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        t_reset_preload();
        t_arith();
        t_zero_reg();
        t_memory();
        t_branch();
        t_illegal();
        done = 1'b1;
        finish_run();
    end

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

endmodule